// File: doc/BRIEF.md
# Parallel Camera Byte-Pair Capture

This block takes the raw bus of an 8-bit parallel image sensor (its byte clock, frame sync, line-valid strobe and data byte) and brings it into the system clock domain. The sensor's byte clock is not forwarded to the fabric. The block oversamples it instead: every sensor signal passes through a multi-flop synchroniser, and each rising edge of the sampled byte clock is found by comparing successive samples. The system clock must run at least twice as fast as the sensor byte clock.

The sensor delivers YUV 4:2:2 data as alternating chroma and luma bytes. The block joins each two bytes into one 16-bit pixel word, with luma in the upper byte and chroma in the lower byte. It raises a one-cycle pixel-enable for each word, so the enable runs at half the sensor byte rate. A separate flag shows whether the chroma byte of the current word is U or V. The downstream logic receives a frame sync with the sensor's polarity and a line-valid signal named hsync, which it uses to frame the enables.

Top module: `cam_pair_capture`

## Requirements
- R1: While `rst` is high at a clock edge, every output is cleared to zero on that edge.
- R2: `vsyncOut` reproduces `sensVsync` with the same polarity, delayed by SYNC_STAGES+1 system clock cycles.
- R3: `hsyncOut` reproduces `sensHref` with the same polarity, delayed by SYNC_STAGES+1 system clock cycles.
- R4: `pixEn` is a single-cycle strobe and is never high on two consecutive cycles.
- R5: `pixEn` is only asserted while `hsyncOut` is high.
- R6: Exactly one `pixEn` is produced for every two sensor bytes sampled while href is high. A 640-byte line (QVGA, 320 pixels) yields 320 enables within one hsync-high period.
- R7: Within each pair, the first byte after href rises (and every odd-numbered byte after it) appears in `pixWord[7:0]` as chroma. The following byte appears in `pixWord[15:8]` as luma.
- R8: `chromaIsV` is 0 (U) for the first pixel of each line and toggles on every later pixel of that line.
- R9: If a line ends with an odd number of bytes, the last byte is dropped. The next line starts a fresh pair with `chromaIsV` = 0.
- R10: While the sensor vsync is high, no `pixEn` is produced and the pairing state is cleared. A byte taken with href high after vsync falls is treated as the first half of a pair, with U chroma.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sensPclk | input | 1 | Sensor byte clock, sampled as data |
| sensVsync | input | 1 | Sensor frame sync, active high |
| sensHref | input | 1 | Sensor line-valid, high during active bytes |
| sensData | input | DATA_W | Sensor data byte |
| vsyncOut | output | 1 | Synchronised frame sync |
| hsyncOut | output | 1 | Synchronised line-valid |
| pixEn | output | 1 | One-cycle pixel-enable |
| pixWord | output | 2*DATA_W | Luma in the upper byte, chroma in the lower byte |
| chromaIsV | output | 1 | 1 when the chroma byte of pixWord is V, 0 for U |

## Verification
On every cycle, assertions check the following: the enable is a single-cycle pulse, it appears only inside hsync-high and never during vsync, the syncs match their inputs delayed by the synchroniser depth, and chroma restarts at U when a line begins. Only the bench scenarios can show byte ordering inside a word, the U/V alternation across a line, the dropped trailing odd byte, and the enable count of a full 640-byte line. The bench also shows that bytes sent during vsync are ignored and that pairing restarts cleanly once vsync falls mid-href.

// File: rtl/cam_pair_pkg.sv
package cam_pair_pkg;
  // Strobes from the pairing control to the datapath
  typedef struct packed {
    logic capFirst;  // latch the first byte of a pair
    logic emitPair;  // second byte present: form and emit a word
    logic chromaV;   // chroma of the word being formed is V
  } pairCtl_t;
endpackage

// File: rtl/cam_pair_sync.sv
module cam_pair_sync #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pclkIn,
  input  logic              vsyncIn,
  input  logic              hrefIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              pclkRise,
  output logic              vsyncS,
  output logic              hrefS,
  output logic [DATA_W-1:0] dataS
);
  localparam int BUS_W = DATA_W + 3;
  localparam int LAST  = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][BUS_W-1:0] stage;
  logic pclkPrev;

  // All sensor lines share one synchroniser chain so they stay aligned
  always_ff @(posedge clk) begin
    if (rst) begin
      stage    <= '0;
      pclkPrev <= 1'b0;
    end else begin
      stage[0] <= {pclkIn, vsyncIn, hrefIn, dataIn};
      for (int s = 1; s < SYNC_STAGES; s++) stage[s] <= stage[s-1];
      pclkPrev <= stage[LAST][BUS_W-1];
    end
  end

  assign pclkRise = stage[LAST][BUS_W-1] & ~pclkPrev;
  assign vsyncS   = stage[LAST][BUS_W-2];
  assign hrefS    = stage[LAST][BUS_W-3];
  assign dataS    = stage[LAST][DATA_W-1:0];

  // The byte clock is slow enough that a rise is never seen twice in a row
  a_r4_rise_spacing: assert property (@(posedge clk) disable iff (rst)
    pclkRise |=> !pclkRise);
endmodule

// File: rtl/cam_pair_ctrl.sv
module cam_pair_ctrl
  import cam_pair_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     pclkRise,
  input  logic     vsyncS,
  input  logic     hrefS,
  output pairCtl_t ctl
);
  logic phase;        // 0: next byte is chroma half, 1: luma half
  logic chromaState;  // chroma of the pair being formed
  logic active;

  assign active = pclkRise & hrefS & ~vsyncS;

  always_comb begin
    ctl          = '0;
    ctl.capFirst = active & ~phase;
    ctl.emitPair = active & phase;
    ctl.chromaV  = chromaState;
  end

  always_ff @(posedge clk) begin
    if (rst || vsyncS || !hrefS) begin
      phase       <= 1'b0;
      chromaState <= 1'b0;
    end else if (active) begin
      phase <= ~phase;
      if (phase) chromaState <= ~chromaState;
    end
  end

  // R8: a new line always starts on U chroma
  a_r8_line_starts_u: assert property (@(posedge clk) disable iff (rst)
    $rose(hrefS) |-> !ctl.chromaV);
  // R9: a pair cannot complete without its first half
  a_r9_no_lone_emit: assert property (@(posedge clk) disable iff (rst)
    $rose(hrefS) |-> !ctl.emitPair);
endmodule

// File: rtl/cam_pair_dpath.sv
module cam_pair_dpath
  import cam_pair_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  pairCtl_t            ctl,
  input  logic [DATA_W-1:0]   dataS,
  input  logic                vsyncS,
  input  logic                hrefS,
  output logic                vsyncOut,
  output logic                hsyncOut,
  output logic                pixEn,
  output logic [2*DATA_W-1:0] pixWord,
  output logic                chromaIsV
);
  logic [DATA_W-1:0] chromaHold;

  always_ff @(posedge clk) begin
    if (rst) begin
      chromaHold <= '0;
      pixWord    <= '0;
      pixEn      <= 1'b0;
      chromaIsV  <= 1'b0;
      vsyncOut   <= 1'b0;
      hsyncOut   <= 1'b0;
    end else begin
      vsyncOut <= vsyncS;
      hsyncOut <= hrefS;
      pixEn    <= ctl.emitPair;
      if (ctl.capFirst) chromaHold <= dataS;
      if (ctl.emitPair) begin
        pixWord   <= {dataS, chromaHold};
        chromaIsV <= ctl.chromaV;
      end
    end
  end

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    pixEn |=> !pixEn);
endmodule

// File: rtl/cam_pair_capture.sv
module cam_pair_capture
  import cam_pair_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sensPclk,
  input  logic                sensVsync,
  input  logic                sensHref,
  input  logic [DATA_W-1:0]   sensData,
  output logic                vsyncOut,
  output logic                hsyncOut,
  output logic                pixEn,
  output logic [2*DATA_W-1:0] pixWord,
  output logic                chromaIsV
);
  localparam int LAT = SYNC_STAGES + 1;

  logic              pclkRise, vsyncS, hrefS;
  logic [DATA_W-1:0] dataS;
  pairCtl_t          ctl;

  cam_pair_sync #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .pclkIn(sensPclk), .vsyncIn(sensVsync),
    .hrefIn(sensHref), .dataIn(sensData), .pclkRise(pclkRise),
    .vsyncS(vsyncS), .hrefS(hrefS), .dataS(dataS));

  cam_pair_ctrl i_ctrl (
    .clk(clk), .rst(rst), .pclkRise(pclkRise), .vsyncS(vsyncS),
    .hrefS(hrefS), .ctl(ctl));

  cam_pair_dpath #(.DATA_W(DATA_W)) i_dpath (
    .clk(clk), .rst(rst), .ctl(ctl), .dataS(dataS), .vsyncS(vsyncS),
    .hrefS(hrefS), .vsyncOut(vsyncOut), .hsyncOut(hsyncOut),
    .pixEn(pixEn), .pixWord(pixWord), .chromaIsV(chromaIsV));

  a_r2_vsync_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(vsyncOut) |-> $past(sensVsync, LAT));
  a_r2_vsync_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(vsyncOut) |-> !$past(sensVsync, LAT));
  a_r3_hsync_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(hsyncOut) |-> $past(sensHref, LAT));
  a_r3_hsync_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(hsyncOut) |-> !$past(sensHref, LAT));
  a_r5_en_in_line: assert property (@(posedge clk) disable iff (rst)
    pixEn |-> hsyncOut);
  a_r10_no_en_in_vsync: assert property (@(posedge clk) disable iff (rst)
    pixEn |-> !vsyncOut);
endmodule

// File: tb/test_cam_pair_capture.sv
module test_cam_pair_capture;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sensPclk = 1'b0;
  logic        sensVsync = 1'b0;
  logic        sensHref = 1'b0;
  logic [7:0]  sensData = '0;
  logic        vsyncOut, hsyncOut, pixEn, chromaIsV;
  logic [15:0] pixWord;

  int checks = 0;
  int failures = 0;
  logic [16:0] expQ[$];     // {chromaIsV, pixWord}
  int lineCount = 0;
  int lastLineCount = -1;
  logic prevHsync = 1'b0;
  logic drvChroma = 1'b0;
  logic [7:0] drvFirst = '0;
  int drvPhase = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cam_pair_capture i_cam_pair_capture (
    .clk(clk), .rst(rst), .sensPclk(sensPclk), .sensVsync(sensVsync),
    .sensHref(sensHref), .sensData(sensData), .vsyncOut(vsyncOut),
    .hsyncOut(hsyncOut), .pixEn(pixEn), .pixWord(pixWord),
    .chromaIsV(chromaIsV));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One sensor byte: 2 cycles pclk low, 2 cycles high
  task automatic sendByte(input logic [7:0] d, input logic href, input logic vs);
    @(negedge clk);
    sensPclk = 1'b0; sensData = d; sensHref = href; sensVsync = vs;
    // expected model from R7, R8, R9, R10
    if (!href || vs) begin
      drvPhase = 0; drvChroma = 1'b0;
    end else if (drvPhase == 0) begin
      drvFirst = d; drvPhase = 1;
    end else begin
      expQ.push_back({drvChroma, d, drvFirst});
      drvChroma = ~drvChroma; drvPhase = 0;
    end
    @(negedge clk);
    @(negedge clk); sensPclk = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) sendByte(8'h00, 1'b0, 1'b0);
  endtask

  task automatic sendLine(input int nBytes, input logic [7:0] seed);
    for (int i = 0; i < nBytes; i++) sendByte(seed + 8'(i * 7), 1'b1, 1'b0);
    idle(3);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (hsyncOut && !prevHsync) lineCount = 0;
      if (!hsyncOut && prevHsync) lastLineCount = lineCount;
      prevHsync = hsyncOut;
      if (pixEn) begin
        lineCount++;
        if (expQ.size() == 0) begin
          checks++; failures++;
          $display("FAIL R6 unexpected pixEn actual=%0h expected=none", pixWord);
        end else begin
          logic [16:0] e;
          e = expQ.pop_front();
          check("R7 word", {15'd0, pixWord}, {15'd0, e[15:0]});
          check("R8 chroma", {31'd0, chromaIsV}, {31'd0, e[16]});
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    sensHref = 1'b1; sensVsync = 1'b1; sensData = 8'hA5; sensPclk = 1'b1;
    repeat (5) @(negedge clk);
    // R1: outputs zero while in reset
    check("R1 outputs", {pixWord, vsyncOut, hsyncOut, pixEn, chromaIsV}, 32'd0);
    sensHref = 1'b0; sensVsync = 1'b0; sensPclk = 1'b0;
    @(negedge clk); rst = 1'b0;
    idle(2);

    // R2: vsync propagation with latency 3
    @(negedge clk); sensVsync = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R2 not yet", {31'd0, vsyncOut}, 32'd0);
    @(negedge clk);
    check("R2 vsync high", {31'd0, vsyncOut}, 32'd1);
    // R10: bytes with href during vsync ignored; vsync drops mid-href
    sendByte(8'h11, 1'b1, 1'b1);
    sendByte(8'h22, 1'b1, 1'b1);
    sendByte(8'h33, 1'b1, 1'b1);
    check("R10 no enables in vsync", 32'(expQ.size()), 32'd0);
    sendByte(8'h44, 1'b1, 1'b0);
    sendByte(8'h55, 1'b1, 1'b0);
    sendByte(8'h66, 1'b1, 1'b0);
    sendByte(8'h77, 1'b1, 1'b0);
    idle(3);
    check("R10 restart pairs", 32'(lastLineCount), 32'd2);
    check("R2 vsync low", {31'd0, vsyncOut}, 32'd0);

    // R3: hsync propagation
    @(negedge clk); sensHref = 1'b1; sensPclk = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R3 not yet", {31'd0, hsyncOut}, 32'd0);
    @(negedge clk);
    check("R3 hsync high", {31'd0, hsyncOut}, 32'd1);
    sensHref = 1'b0;
    repeat (4) @(negedge clk);
    check("R3 hsync low", {31'd0, hsyncOut}, 32'd0);
    check("R5 no pairs from bare href", 32'(lastLineCount), 32'd0);

    // R6/R7/R8: even line
    sendLine(8, 8'h10);
    check("R6 eight bytes", 32'(lastLineCount), 32'd4);
    // R9: odd line, last byte dropped, next line fresh
    sendLine(7, 8'h80);
    check("R9 odd line", 32'(lastLineCount), 32'd3);
    sendLine(6, 8'hC3);
    check("R9 fresh line", 32'(lastLineCount), 32'd3);
    // R6: QVGA line
    sendLine(640, 8'h01);
    check("R6 QVGA line", 32'(lastLineCount), 32'd320);

    idle(4);
    check("R6 scoreboard drained", 32'(expQ.size()), 32'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule